// File: doc/BRIEF.md
# Lookup-Table Checksum Verification Sequencer

This block checks that lookup tables loaded earlier still hold the contents they were loaded with. A write to an action register starts it. It then takes four-word records from a monitor FIFO. Each record names a table and gives the identifier and the 22-bit checksum that table should carry. Records that do not fit the allowed template are dropped. For every record that fits, the block reads the whole table through a one-cycle-latency memory port. It picks up the identifier held at the table's top address and folds every word into a CRC. It then pushes a four-word result record, which carries per-record mismatch flags, into a verification FIFO.

While a run is in progress the block reports busy, and any access to another target on the bus ends with a bus error. When the monitor FIFO runs dry, the run ends with a done flag and a sticky fail flag. The fail flag is the OR of the mismatches over every record that was checked. The FIFO storage and the bus decoder sit outside the block. A separate reset pulse aborts a run and clears the flags.

Top module: `lut_crc_verifier`

## Requirements
- R1: A write to the action register starts a run only when data bit 2 is 1 and the sequencer is idle. All other data bits have no effect, and a write with bit 2 clear leaves the sequencer idle.
- R2: A record is four words. Bits 15:14 carry the word's position (0 to 3). Word 1 is {00, six one-hot chip bits in 13:8, 00, muon in 5:4 with value 1 to 3, table type in 3:0 with value 1, 2, 3, 4 or 8}. Word 2 holds the expected identifier in 11:0. Words 3 and 4 hold the expected CRC bits 10:0 and 21:11 in 10:0, with parity in bit 11. Bits 13:12 of words 2 to 4 must be 0.
- R3: A record that breaks any rule in R2 is skipped: it produces no result words and does not affect the fail flag. The record after it is still processed.
- R4: For a valid record, the block reads every address {chip index, muon, type, i}, for i from 0 up to the top index. The identifier result is bits 11:0 of the word read at the top index.
- R5: The CRC starts at zero. It takes each read word MSB first, one bit at a time: feedback = crc[21] XOR data bit; crc = (crc << 1) XOR (feedback ? POLY : 0).
- R6: The result record is: word 1 repeated unchanged; {01, 0, identifier-mismatch, identifier read}; {10, 00, even parity of CRC[10:0], CRC[10:0]}; {11, 0, CRC-mismatch, even parity of CRC[21:11], CRC[21:11]}. The identifier-mismatch bit is in bit 12 of result word 2, and the CRC-mismatch bit is in bit 12 of result word 4.
- R7: The fail flag is the OR of both mismatch flags over all records that were not skipped. A start command clears it.
- R8: The done flag is set when the monitor FIFO is empty at a record fetch. A partly fetched record is then dropped. The next start command or the reset pulse clears done.
- R9: Busy is 1 from the cycle after a start until the run ends. While busy is 1, a bus access to another target raises the bus error output in the same cycle.
- R10: The status word is {full, empty, done, busy, fail, 0, count[9:0]}. The count and the full and empty flags come from the verification FIFO's word count.
- R11: The reset pulse returns the sequencer to idle in the next cycle and clears done and fail, even in the middle of a record. No further result words are pushed after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| act_wr | input | 1 | Write strobe for the action register |
| act_data | input | 16 | Action register write data |
| seq_clr | input | 1 | Reset pulse for the sequencer and the verification FIFO |
| tgt_sel | input | 1 | A bus access addresses another target |
| bus_err | output | 1 | End that access with a bus error |
| mf_empty | input | 1 | Monitor FIFO is empty |
| mf_data | input | 16 | Head word of the monitor FIFO (show-ahead) |
| mf_rd | output | 1 | Pop the monitor FIFO |
| mem_rd_en | output | 1 | Table read request |
| mem_addr | output | 9+TBL_AW | Table read address |
| mem_rdata | input | 16 | Table read data, one cycle after the request |
| vf_count | input | $clog2(VF_DEPTH)+1 | Word count of the verification FIFO |
| vf_push | output | 1 | Push a result word |
| vf_data | output | 16 | Result word |
| stat_word | output | 16 | Status word |

## Verification
A wrong template decode shows up at once as a result record that appears or goes missing. A CRC step or feedback tap that is off by one changes both checksum words of every result. The bench therefore sweeps every legal chip, muon and type, and every illegal type code. A read-pipeline offset of one cycle shifts the word taken as the identifier, which shows in result word 2 of the first record. Flag mistakes (fail not sticky, done not cleared, busy still high after the reset pulse) appear in the status word within one cycle of the event that should change them.

// File: rtl/lcv_pkg.sv
package lcv_pkg;
   localparam int WORD_W = 16;
   localparam int CRC_W  = 22;
   localparam int ID_W   = 12;
   localparam int CHIP_N = 6;
   localparam int CIDX_W = 3;
   localparam int SEL_W  = CIDX_W + 2 + 4;

   typedef logic [WORD_W-1:0] word_t;

   typedef enum logic [2:0] {
      S_IDLE, S_FETCH, S_CHECK, S_SCAN, S_DRAIN, S_EMIT
   } seq_st_t;

   // one data word into the checksum, most significant bit first
   function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                 input word_t d,
                                                 input logic [CRC_W-1:0] poly);
      logic [CRC_W-1:0] r;
      logic fb;
      r = c;
      for (int i = WORD_W-1; i >= 0; i--) begin
         fb = r[CRC_W-1] ^ d[i];
         r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
      end
      return r;
   endfunction

   function automatic logic kind_ok(input logic [3:0] k);
      return (k == 4'd1) || (k == 4'd2) || (k == 4'd3) || (k == 4'd4) || (k == 4'd8);
   endfunction
endpackage

// File: rtl/lcv_rec_check.sv
module lcv_rec_check
   import lcv_pkg::*;
(
   input  logic [3:0][WORD_W-1:0] rec,
   output logic                   rec_ok,
   output logic [CIDX_W-1:0]      chip_idx
);
   logic [3:0] tag_ok;
   logic [CHIP_N-1:0] chips;

   assign chips = rec[0][8 +: CHIP_N];

   genvar g;
   generate
      for (g = 0; g < 4; g++) begin : g_tag
         assign tag_ok[g] = (rec[g][15:14] == 2'(g));
      end
   endgenerate

   always_comb begin
      chip_idx = '0;
      for (int j = 0; j < CHIP_N; j++)
         if (chips[j]) chip_idx = CIDX_W'(j);
   end

   always_comb begin
      rec_ok = (&tag_ok)
             && $onehot(chips)
             && (rec[0][7:6] == 2'b00)
             && (rec[0][5:4] != 2'b00)
             && kind_ok(rec[0][3:0])
             && (rec[1][13:12] == 2'b00)
             && (rec[2][13:12] == 2'b00)
             && (rec[3][13:12] == 2'b00);
   end
endmodule

// File: rtl/lcv_crc_acc.sv
module lcv_crc_acc
   import lcv_pkg::*;
#(
   parameter logic [CRC_W-1:0] POLY = 22'h2B4C35
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             en,
   input  word_t            din,
   output logic [CRC_W-1:0] crc
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   crc <= '0;
      else if (clr) crc <= '0;
      else if (en)  crc <= crc_step(crc, din, POLY);
   end

   // R5
   crc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!en && !clr) |=> $stable(crc));
endmodule

// File: rtl/lcv_res_fmt.sv
module lcv_res_fmt
   import lcv_pkg::*;
(
   input  logic [3:0][WORD_W-1:0] rec,
   input  logic [ID_W-1:0]        id_rd,
   input  logic [CRC_W-1:0]       crc,
   output logic [3:0][WORD_W-1:0] res,
   output logic                   any_bad
);
   logic [CRC_W-1:0] crc_exp;
   logic id_bad, crc_bad;

   assign crc_exp = {rec[3][10:0], rec[2][10:0]};
   assign id_bad  = (id_rd != rec[1][ID_W-1:0]);
   assign crc_bad = (crc != crc_exp);
   assign any_bad = id_bad | crc_bad;

   assign res[0] = rec[0];
   assign res[1] = {2'b01, 1'b0, id_bad, id_rd};
   assign res[2] = {2'b10, 2'b00, ^crc[10:0], crc[10:0]};
   assign res[3] = {2'b11, 1'b0, crc_bad, ^crc[21:11], crc[21:11]};
endmodule

// File: rtl/lut_crc_verifier.sv
module lut_crc_verifier
   import lcv_pkg::*;
#(
   parameter int               TBL_AW    = 4,
   parameter logic [CRC_W-1:0] CRC_POLY  = 22'h2B4C35,
   parameter int               VF_DEPTH  = 1024,
   parameter int               START_BIT = 2,
   localparam int              ADDR_W    = SEL_W + TBL_AW,
   localparam int              CNT_W     = $clog2(VF_DEPTH)
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              act_wr,
   input  logic [15:0]       act_data,
   input  logic              seq_clr,
   input  logic              tgt_sel,
   output logic              bus_err,
   input  logic              mf_empty,
   input  logic [15:0]       mf_data,
   output logic              mf_rd,
   output logic              mem_rd_en,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic [15:0]       mem_rdata,
   input  logic [CNT_W:0]    vf_count,
   output logic              vf_push,
   output logic [15:0]       vf_data,
   output logic [15:0]       stat_word
);
   localparam int PAD_W = 11 - CNT_W;
   localparam logic [TBL_AW-1:0] TOP_IDX = '1;

   generate
      if (TBL_AW < 1 || TBL_AW > 16) begin : g_bad_aw
         $error("TBL_AW out of range");
      end
      if (VF_DEPTH < 4 || VF_DEPTH > 1024 || (1 << CNT_W) != VF_DEPTH) begin : g_bad_depth
         $error("VF_DEPTH must be a power of two, 4..1024");
      end
      if (START_BIT < 0 || START_BIT > 15) begin : g_bad_bit
         $error("START_BIT out of range");
      end
   endgenerate

   seq_st_t                state;
   logic [3:0][WORD_W-1:0] rec_q;
   logic [1:0]             wcnt, ecnt;
   logic [TBL_AW-1:0]      idx;
   logic                   rd_v, rd_last;
   logic [ID_W-1:0]        id_rd;
   logic                   done_q, fail_q;
   logic                   busy, start_go, vf_full, rec_ok, any_bad;
   logic [CIDX_W-1:0]      chip_idx;
   logic [CRC_W-1:0]       crc;
   logic [3:0][WORD_W-1:0] res;

   assign busy     = (state != S_IDLE);
   assign start_go = act_wr && act_data[START_BIT] && !busy && !seq_clr;
   assign vf_full  = (vf_count == (CNT_W+1)'(VF_DEPTH));
   assign bus_err  = tgt_sel && busy;

   lcv_rec_check u_chk (.rec(rec_q), .rec_ok(rec_ok), .chip_idx(chip_idx));

   lcv_crc_acc #(.POLY(CRC_POLY)) u_crc (
      .clk(clk), .rst_n(rst_n), .clr(state == S_CHECK), .en(rd_v),
      .din(mem_rdata), .crc(crc));

   lcv_res_fmt u_fmt (.rec(rec_q), .id_rd(id_rd), .crc(crc), .res(res), .any_bad(any_bad));

   assign mf_rd     = (state == S_FETCH) && !mf_empty && !seq_clr;
   assign mem_rd_en = (state == S_SCAN);
   assign mem_addr  = {chip_idx, rec_q[0][5:4], rec_q[0][3:0], idx};
   assign vf_push   = (state == S_EMIT) && !vf_full && !seq_clr;
   assign vf_data   = res[ecnt];
   assign stat_word = {vf_full, (vf_count == '0), done_q, busy, fail_q,
                       {PAD_W{1'b0}}, vf_count[CNT_W-1:0]};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= S_IDLE; rec_q <= '0; wcnt <= '0; ecnt <= '0; idx <= '0;
         rd_v <= 1'b0; rd_last <= 1'b0; id_rd <= '0; done_q <= 1'b0; fail_q <= 1'b0;
      end else if (seq_clr) begin
         state <= S_IDLE; wcnt <= '0; ecnt <= '0;
         rd_v <= 1'b0; rd_last <= 1'b0; done_q <= 1'b0; fail_q <= 1'b0;
      end else begin
         rd_v    <= (state == S_SCAN);
         rd_last <= (state == S_SCAN) && (idx == TOP_IDX);
         if (rd_v && rd_last) id_rd <= mem_rdata[ID_W-1:0];
         case (state)
            S_IDLE: if (start_go) begin
               state <= S_FETCH; wcnt <= '0; done_q <= 1'b0; fail_q <= 1'b0;
            end
            S_FETCH: if (mf_empty) begin
               state <= S_IDLE; done_q <= 1'b1; wcnt <= '0;
            end else begin
               rec_q[wcnt] <= mf_data;
               wcnt        <= wcnt + 2'd1;
               if (wcnt == 2'd3) state <= S_CHECK;
            end
            S_CHECK: begin
               idx   <= '0;
               state <= rec_ok ? S_SCAN : S_FETCH;
            end
            S_SCAN: begin
               idx <= idx + 1'b1;
               if (idx == TOP_IDX) state <= S_DRAIN;
            end
            S_DRAIN: begin
               state <= S_EMIT; ecnt <= '0;
            end
            S_EMIT: if (!vf_full) begin
               ecnt <= ecnt + 2'd1;
               if (ecnt == 2'd0) fail_q <= fail_q | any_bad;
               if (ecnt == 2'd3) state <= S_FETCH;
            end
            default: state <= S_IDLE;
         endcase
      end
   end

   // R1
   start_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
      start_go |=> busy);
   // R8
   done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(done_q && busy));
   // R7
   fail_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fail_q) |-> $past(state == S_EMIT));
   // R11
   clr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      seq_clr |=> (!busy && !done_q && !fail_q));
   // R4
   port_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(mf_rd && (vf_push || mem_rd_en)));
endmodule

// File: tb/lut_crc_verifier_tb.sv
module lut_crc_verifier_tb;
   localparam int TAW = 3;
   localparam int AW  = 9 + TAW;
   localparam logic [21:0] POLY = 22'h2B4C35;

   logic clk = 0, rst_n = 0;
   logic act_wr = 0, seq_clr = 0, tgt_sel = 0;
   logic [15:0] act_data = '0;
   logic bus_err, mf_rd, mem_rd_en, vf_push;
   logic [AW-1:0] mem_addr;
   logic [15:0] mem_rdata, vf_data, stat_word, mf_data;
   logic mf_empty;
   logic [10:0] vf_count;

   logic [15:0] mf_arr [0:511];
   int mf_wp = 0, mf_rp = 0;
   logic [15:0] res_arr [0:1023];
   int res_n = 0;
   logic [15:0] exp_arr [0:1023];
   int exp_n = 0;
   int checks = 0, fails = 0;

   always #5 clk = ~clk;

   lut_crc_verifier #(.TBL_AW(TAW), .CRC_POLY(POLY), .VF_DEPTH(1024)) u_dut (
      .clk(clk), .rst_n(rst_n), .act_wr(act_wr), .act_data(act_data),
      .seq_clr(seq_clr), .tgt_sel(tgt_sel), .bus_err(bus_err),
      .mf_empty(mf_empty), .mf_data(mf_data), .mf_rd(mf_rd),
      .mem_rd_en(mem_rd_en), .mem_addr(mem_addr), .mem_rdata(mem_rdata),
      .vf_count(vf_count), .vf_push(vf_push), .vf_data(vf_data), .stat_word(stat_word));

   function automatic logic [15:0] memval(input logic [AW-1:0] a);
      logic [15:0] x;
      x = 16'(a) * 16'h9E37;
      return x ^ {a[3:0], a} ^ 16'h5A5A;
   endfunction

   assign mf_empty = (mf_rp == mf_wp);
   assign mf_data  = mf_arr[mf_rp[8:0]];
   assign vf_count = 11'(res_n);

   always @(posedge clk) begin
      if (mem_rd_en) mem_rdata <= memval(mem_addr);
      if (seq_clr) begin
         mf_rp <= mf_wp;
         res_n <= 0;
      end else begin
         if (mf_rd) mf_rp <= mf_rp + 1;
         if (vf_push) begin
            res_arr[res_n[9:0]] <= vf_data;
            res_n <= res_n + 1;
         end
      end
   end

   task automatic check(input logic ok, input string tag, input logic [31:0] act, input logic [31:0] expv);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
      end
   endtask

   function automatic logic [21:0] tb_crc(input logic [8:0] base);
      logic [21:0] c;
      logic [15:0] d;
      logic fb;
      c = '0;
      for (int i = 0; i < (1 << TAW); i++) begin
         d = memval({base, TAW'(i)});
         for (int b = 15; b >= 0; b--) begin
            fb = c[21] ^ d[b];
            c = {c[20:0], 1'b0};
            if (fb) c = c ^ POLY;
         end
      end
      return c;
   endfunction

   task automatic mk_words(input int cidx, input int mu, input int kind,
                           output logic [15:0] w1, output logic [15:0] w2,
                           output logic [15:0] w3, output logic [15:0] w4);
      logic [8:0] base;
      logic [21:0] c;
      logic [11:0] id;
      base = {3'(cidx), 2'(mu), 4'(kind)};
      c  = tb_crc(base);
      id = memval({base, {TAW{1'b1}}})[11:0];
      w1 = {2'b00, 6'(1 << cidx), 2'b00, 2'(mu), 4'(kind)};
      w2 = {2'b01, 2'b00, id};
      w3 = {2'b10, 2'b00, ^c[10:0], c[10:0]};
      w4 = {2'b11, 2'b00, ^c[21:11], c[21:11]};
   endtask

   task automatic add_raw(input logic [15:0] w1, input logic [15:0] w2,
                          input logic [15:0] w3, input logic [15:0] w4);
      mf_arr[mf_wp] = w1; mf_arr[mf_wp+1] = w2; mf_arr[mf_wp+2] = w3; mf_arr[mf_wp+3] = w4;
      mf_wp = mf_wp + 4;
   endtask

   task automatic add_rec(input int cidx, input int mu, input int kind, input logic bad_id, input logic bad_crc);
      logic [15:0] w1, w2, w3, w4;
      mk_words(cidx, mu, kind, w1, w2, w3, w4);
      exp_arr[exp_n]   = w1;
      exp_arr[exp_n+1] = {w2[15:13], bad_id, w2[11:0]};
      exp_arr[exp_n+2] = w3;
      exp_arr[exp_n+3] = {w4[15:13], bad_crc, w4[11:0]};
      exp_n = exp_n + 4;
      if (bad_id)  w2 = w2 ^ 16'h0001;
      if (bad_crc) w4 = w4 ^ 16'h0004;
      add_raw(w1, w2, w3, w4);
   endtask

   task automatic clr_pulse();
      @(negedge clk); seq_clr = 1;
      @(negedge clk); seq_clr = 0;
      mf_wp = mf_rp;
      exp_n = 0;
   endtask

   task automatic start(input logic [15:0] d);
      @(negedge clk); act_wr = 1; act_data = d;
      @(negedge clk); act_wr = 0; act_data = '0;
   endtask

   task automatic wait_done(input string tag);
      int n;
      n = 0;
      while (!stat_word[13] && n < 5000) begin
         @(negedge clk); n++;
      end
      check(stat_word[13] == 1'b1, {tag, " done flag"}, 32'(stat_word[13]), 1);
   endtask

   task automatic cmp_results(input string tag);
      check(res_n == exp_n, {tag, " result count"}, 32'(res_n), 32'(exp_n));
      for (int i = 0; i + 3 < exp_n && i + 3 < res_n; i = i + 4) begin
         logic ok;
         ok = 1;
         for (int k = 0; k < 4; k++) if (res_arr[i+k] !== exp_arr[i+k]) ok = 0;
         for (int k = 0; k < 4; k++)
            if (res_arr[i+k] !== exp_arr[i+k])
               $display("  record %0d word %0d got %h want %h", i/4, k+1, res_arr[i+k], exp_arr[i+k]);
         check(ok, {tag, " result record"}, 32'(i/4), 32'(i/4));
      end
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      $display("FAIL watchdog R8 actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails + 1);
      $finish;
   end

   initial begin
      logic [15:0] w1, w2, w3, w4;
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R10 reset state: empty only
      check(stat_word == 16'h4000, "R10 reset status", 32'(stat_word), 32'h4000);
      tgt_sel = 1; #1;
      check(bus_err == 1'b0, "R9 no error when idle", 32'(bus_err), 0);
      tgt_sel = 0;

      // R2 R4 R5 R6 sweep of every legal table selection
      clr_pulse();
      for (int c = 0; c < 6; c++)
         for (int m = 1; m < 4; m++)
            for (int k = 1; k <= 8; k++)
               if (k == 1 || k == 2 || k == 3 || k == 4 || k == 8) add_rec(c, m, k, 0, 0);
      start(16'h0004);
      check(stat_word[12] == 1'b1, "R9 busy after start", 32'(stat_word[12]), 1);
      tgt_sel = 1; #1;
      check(bus_err == 1'b1, "R9 bus error while busy", 32'(bus_err), 1);
      tgt_sel = 0;
      wait_done("R4 R5 sweep");
      cmp_results("R6 sweep");
      check(stat_word == {3'b001, 3'b000, 10'd360}, "R10 status after sweep",
            32'(stat_word), 32'({3'b001, 3'b000, 10'd360}));

      // R1 write with bit 2 clear does nothing
      clr_pulse();
      add_rec(0, 1, 1, 0, 0);
      start(16'hFFFB);
      repeat (5) @(negedge clk);
      check(stat_word[12] == 1'b0, "R1 no start without bit 2", 32'(stat_word[12]), 0);
      check(res_n == 0, "R1 no results without bit 2", 32'(res_n), 0);
      // R1 all bits set still starts
      start(16'hFFFF);
      wait_done("R1 start with all bits");
      cmp_results("R1 start with all bits");

      // R3 malformed records are skipped; a good record after them still works
      clr_pulse();
      for (int k = 0; k < 16; k++)
         if (!(k == 1 || k == 2 || k == 3 || k == 4 || k == 8)) begin
            mk_words(0, 1, 1, w1, w2, w3, w4);
            add_raw({w1[15:4], 4'(k)}, w2, w3, w4);
         end
      mk_words(2, 2, 3, w1, w2, w3, w4);
      add_raw({w1[15:6], 2'b00, w1[3:0]}, w2, w3, w4);       // muon 0
      add_raw({w1[15:14], 6'b000000, w1[7:0]}, w2, w3, w4);  // no chip
      add_raw({w1[15:14], 6'b000011, w1[7:0]}, w2, w3, w4);  // two chips
      add_raw(w1 | 16'h0040, w2, w3, w4);                    // fixed bit word 1
      add_raw(w1, w2 | 16'h2000, w3, w4);                    // fixed bit word 2
      add_raw(w1, w2, w3 | 16'h1000, w4);                    // fixed bit word 3
      add_raw(w1, w2, w3, w4 | 16'h2000);                    // fixed bit word 4
      add_raw(w1 | 16'h4000, w2, w3, w4);                    // wrong tag word 1
      add_raw(w1, w2, w3 | 16'h4000, w4);                    // wrong tag word 3
      add_rec(5, 3, 8, 0, 0);
      start(16'h0004);
      wait_done("R3 skip");
      cmp_results("R3 skip");
      check(stat_word[11] == 1'b0, "R3 skipped records leave fail clear", 32'(stat_word[11]), 0);

      // R5 R6 R7 identifier mismatch then good record: fail stays set
      clr_pulse();
      add_rec(1, 2, 4, 1, 0);
      add_rec(3, 1, 2, 0, 0);
      start(16'h0004);
      wait_done("R6 id mismatch");
      cmp_results("R6 id mismatch");
      check(stat_word[11] == 1'b1, "R7 fail sticky after id mismatch", 32'(stat_word[11]), 1);

      // R6 R7 checksum mismatch
      clr_pulse();
      add_rec(4, 3, 1, 0, 1);
      start(16'h0004);
      check(stat_word[11] == 1'b0, "R7 start clears fail", 32'(stat_word[11]), 0);
      check(stat_word[13] == 1'b0, "R8 start clears done", 32'(stat_word[13]), 0);
      wait_done("R6 crc mismatch");
      cmp_results("R6 crc mismatch");
      check(stat_word[11] == 1'b1, "R7 fail after crc mismatch", 32'(stat_word[11]), 1);

      // R7 good run after failed run clears fail
      clr_pulse();
      add_rec(0, 3, 3, 0, 0);
      start(16'h0004);
      wait_done("R7 clean run");
      check(stat_word[11] == 1'b0, "R7 fail clear on clean run", 32'(stat_word[11]), 0);

      // R8 partial record dropped at end of data
      clr_pulse();
      mk_words(0, 1, 1, w1, w2, w3, w4);
      mf_arr[mf_wp] = w1; mf_arr[mf_wp+1] = w2; mf_wp = mf_wp + 2;
      start(16'h0004);
      wait_done("R8 partial");
      check(res_n == 0, "R8 partial record gives no result", 32'(res_n), 0);
      check(stat_word[12] == 1'b0, "R8 idle after partial", 32'(stat_word[12]), 0);

      // R11 reset pulse in the middle of a table scan
      clr_pulse();
      add_rec(0, 1, 1, 0, 0);
      add_rec(1, 1, 1, 0, 0);
      start(16'h0004);
      repeat (6) @(negedge clk);
      check(stat_word[12] == 1'b1, "R11 busy before abort", 32'(stat_word[12]), 1);
      @(negedge clk); seq_clr = 1;
      @(negedge clk); seq_clr = 0;
      check(stat_word[12] == 1'b0, "R11 idle after abort", 32'(stat_word[12]), 0);
      check(stat_word[13] == 1'b0, "R11 done clear after abort", 32'(stat_word[13]), 0);
      tgt_sel = 1; #1;
      check(bus_err == 1'b0, "R9 no error after abort", 32'(bus_err), 0);
      tgt_sel = 0;
      repeat (40) @(negedge clk);
      check(res_n == 0, "R11 no pushes after abort", 32'(res_n), 0);
      check(stat_word == 16'h4000, "R10 R11 status after abort", 32'(stat_word), 32'h4000);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule